// File: doc/BRIEF.md
# Two-State Trellis Check-Node Processor

This block produces every outgoing message of one parity check in a layered message-passing decoder. The check is modelled as a two-state trellis (even parity, odd parity). The incoming edge messages arrive one per accepted cycle, and no channel branch metric enters the trellis. While the messages arrive, a forward metric is updated and saved in a small per-edge store. A backward pass then runs over the edges from last to first and forms the extrinsic result for each edge. The results are then streamed out in the same edge order as the inputs.

Every recursion step and every extrinsic result has the same kernel. The kernel is the max* of the two operands minus the max* of their sum and zero. max* is a saturating maximum plus a table correction. Arithmetic runs on a common fine grid of one quarter LLR unit. Messages are coarser by a factor of `2**SH_MU` and metrics by `2**SH_A`. Each operand is left-shifted onto the fine grid, and each result is arithmetically right-shifted back to its own grid and saturated symmetrically. Saved forward metrics lose `T_A` low bits and are clamped to `M_A` bits to save storage.

Top module: `cnp_check_node`

## Requirements
- R1: While reset is held, and immediately after it, `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: The forward metric starts at `L = 2**(N_A-1)-1`. Each accepted message m updates it: `a' = step(a, m)`, where the result is placed on the metric grid (right shift by SH_A) and saturated to ±L.
- R3: The backward metric starts at L on the last edge and is updated with the same step, running from the last edge to the first. The output for edge k is `step(rd_k, b_{k+1})`. It is placed on the message grid (right shift by SH_MU) and saturated to ±(2**(N_MU-1)-1).
- R4: max*(p,q) = min(max(p,q) + c(|p−q|), 2**(W−1)−1) on the fine grid, where W = max(N_A+SH_A, N_MU+SH_MU)+2. The correction c is 3 for d=0, 2 for d in 1..3, 1 for d in 4..8, and 0 above.
- R5: A message is multiplied by 2**SH_MU and a metric by 2**SH_A before any sum or comparison. Right shifts are arithmetic, rounding towards minus infinity.
- R6: The saved forward metric of edge k is `rd_k = clamp(a_k >>> T_A, ±(2**(M_A-1)-1)) * 2**T_A`.
- R7: Exactly as many outputs are produced as edges were accepted, in input order. `out_last_o` is 1 only with the final one.
- R8: If the last edge is accepted at clock edge P and the degree is d, the outputs are valid on the d consecutive cycles that follow clock edge P+d.
- R9: `in_ready_o` drops in the cycle after the last edge and rises again after the final output. `in_valid_i` has no effect while it is low.
- R10: When MAX_DEG edges have been accepted, the check closes even if `in_last_i` was not set.
- R11: `out_msg_o` never carries the most negative code −2**(N_MU−1).
- R12: Cycles with `in_valid_i` low during input add no edge and do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Edge message present |
| in_msg_i | input | N_MU | Incoming edge message, two's complement |
| in_last_i | input | 1 | Marks the final edge of the check |
| in_ready_o | output | 1 | Block accepts edge messages |
| out_valid_o | output | 1 | Outgoing message present |
| out_msg_o | output | N_MU | Outgoing extrinsic message, two's complement |
| out_last_o | output | 1 | Marks the final outgoing message |

## Verification
After the final edge is accepted, `in_ready_o` is expected low one cycle later. `out_valid_o` must stay low for exactly d cycles and then stay high for d cycles. After that, the block must be ready again. The bench drives on falling edges and counts falling edges from the accepting rising edge. It checks output absence on each of the first d samples, then one value and marker per sample for the next d, then the return to ready. Inputs poked during the busy window and idle gaps during input are placed on those same counted samples.

// File: rtl/cnp_pkg.sv
package cnp_pkg;

  typedef enum logic [1:0] {ST_IN, ST_BWD, ST_OUT} cnp_state_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // log(1+exp(-d/4))*4, rounded, fine grid of a quarter unit
  function automatic int unsigned corr_q2(input int unsigned d);
    if (d == 0) return 3;
    else if (d <= 3) return 2;
    else if (d <= 8) return 1;
    else return 0;
  endfunction

endpackage

// File: rtl/cnp_maxstar.sv
module cnp_maxstar #(
  parameter int W = 10
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] z_o
);
  localparam logic signed [W:0] LIM = (W+1)'(2**(W-1)-1);

  logic signed [W:0] diff, mx, sum;
  logic [W:0]        mag;
  logic [1:0]        corr;

  always_comb begin
    diff = $signed({a_i[W-1], a_i}) - $signed({b_i[W-1], b_i});
    mag  = diff[W] ? $unsigned(-diff) : $unsigned(diff);
    mx   = diff[W] ? $signed({b_i[W-1], b_i}) : $signed({a_i[W-1], a_i});
    if (mag > (W+1)'(15)) corr = 2'd0;
    else                  corr = 2'(cnp_pkg::corr_q2(32'(mag)));
    sum  = mx + $signed({{(W-1){1'b0}}, corr});
    z_o  = (sum > LIM) ? LIM[W-1:0] : sum[W-1:0];
  end
endmodule

// File: rtl/cnp_step.sv
// z = max*(x,y) - max*(x+y,0) on the fine grid, shifted back and clamped
module cnp_step #(
  parameter int XW = 8,
  parameter int XS = 0,
  parameter int YW = 6,
  parameter int YS = 1,
  parameter int OW = 8,
  parameter int OS = 0
) (
  input  logic signed [XW-1:0] x_i,
  input  logic signed [YW-1:0] y_i,
  output logic signed [OW-1:0] z_o
);
  localparam int W = cnp_pkg::max_i(XW + XS, YW + YS) + 2;
  localparam logic signed [W:0] OLIM = (W+1)'(2**(OW-1)-1);
  localparam logic signed [W:0] ONEG = -OLIM;

  logic signed [W-1:0] xf, yf, sf, m1, m2;
  logic signed [W:0]   d, q;

  assign xf = W'(x_i) <<< XS;
  assign yf = W'(y_i) <<< YS;
  assign sf = xf + yf;

  cnp_maxstar #(.W(W)) u_ms_xy  (.a_i(xf), .b_i(yf), .z_o(m1));
  cnp_maxstar #(.W(W)) u_ms_sum (.a_i(sf), .b_i('0), .z_o(m2));

  always_comb begin
    d = $signed({m1[W-1], m1}) - $signed({m2[W-1], m2});
    q = d >>> OS;
    if (q > OLIM)      z_o = OLIM[OW-1:0];
    else if (q < ONEG) z_o = ONEG[OW-1:0];
    else               z_o = q[OW-1:0];
  end
endmodule

// File: rtl/cnp_check_node.sv
module cnp_check_node #(
  parameter int MAX_DEG = 16,
  parameter int N_MU    = 6,
  parameter int SH_MU   = 1,
  parameter int N_A     = 8,
  parameter int SH_A    = 0,
  parameter int T_A     = 1,
  parameter int M_A     = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [N_MU-1:0] in_msg_i,
  input  logic            in_last_i,
  output logic            in_ready_o,
  output logic            out_valid_o,
  output logic [N_MU-1:0] out_msg_o,
  output logic            out_last_o
);
  import cnp_pkg::*;

  localparam int IDX_W = (MAX_DEG > 2) ? $clog2(MAX_DEG) : 1;
  localparam int RD_W  = M_A + T_A;
  localparam logic signed [N_A-1:0] A_INIT = N_A'(2**(N_A-1)-1);
  localparam logic signed [N_A-1:0] SLIM   = N_A'(2**(M_A-1)-1);
  localparam logic signed [N_A-1:0] SNEG   = -SLIM;
  localparam logic [IDX_W-1:0]      IDX_END = IDX_W'(MAX_DEG-1);

  cnp_state_e state_q;
  logic signed [N_A-1:0]  alpha_q, beta_q;
  logic [IDX_W-1:0]       idx_q, last_idx_q;
  logic signed [N_MU-1:0] mem_mu [MAX_DEG];  // messages, then extrinsic results
  logic signed [M_A-1:0]  mem_a  [MAX_DEG];

  logic accept;
  logic signed [N_A-1:0]  met_x, met_nxt, a_sh;
  logic signed [N_MU-1:0] met_y, ext;
  logic signed [M_A-1:0]  a_st;
  logic signed [RD_W-1:0] a_rd;

  assign accept = in_valid_i && (state_q == ST_IN);
  assign met_x  = (state_q == ST_IN) ? alpha_q : beta_q;
  assign met_y  = (state_q == ST_IN) ? $signed(in_msg_i) : mem_mu[idx_q];

  always_comb begin
    a_sh = alpha_q >>> T_A;
    if (a_sh > SLIM)      a_st = SLIM[M_A-1:0];
    else if (a_sh < SNEG) a_st = SNEG[M_A-1:0];
    else                  a_st = a_sh[M_A-1:0];
  end

  assign a_rd = RD_W'(mem_a[idx_q]) <<< T_A;

  // one metric kernel shared by the forward and backward passes
  cnp_step #(.XW(N_A), .XS(SH_A), .YW(N_MU), .YS(SH_MU), .OW(N_A), .OS(SH_A)) u_met (
    .x_i(met_x), .y_i(met_y), .z_o(met_nxt)
  );

  cnp_step #(.XW(RD_W), .XS(SH_A), .YW(N_A), .YS(SH_A), .OW(N_MU), .OS(SH_MU)) u_ext (
    .x_i(a_rd), .y_i(beta_q), .z_o(ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IN;
      alpha_q    <= A_INIT;
      beta_q     <= A_INIT;
      idx_q      <= '0;
      last_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IN: if (accept) begin
          if (in_last_i || idx_q == IDX_END) begin
            state_q    <= ST_BWD;
            last_idx_q <= idx_q;
            alpha_q    <= A_INIT;
            beta_q     <= A_INIT;
          end else begin
            idx_q   <= idx_q + 1'b1;
            alpha_q <= met_nxt;
          end
        end
        ST_BWD: begin
          beta_q <= met_nxt;
          if (idx_q == '0) state_q <= ST_OUT;
          else             idx_q   <= idx_q - 1'b1;
        end
        ST_OUT: begin
          if (idx_q == last_idx_q) begin
            state_q <= ST_IN;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IN;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) begin
      mem_mu[idx_q] <= $signed(in_msg_i);
      mem_a[idx_q]  <= a_st;
    end else if (state_q == ST_BWD) begin
      mem_mu[idx_q] <= ext;
    end
  end

  assign in_ready_o  = (state_q == ST_IN);
  assign out_valid_o = (state_q == ST_OUT);
  assign out_msg_o   = mem_mu[idx_q];
  assign out_last_o  = (state_q == ST_OUT) && (idx_q == last_idx_q);

endmodule

// File: rtl/cnp_check_node_chk.sv
module cnp_check_node_chk #(
  parameter int MAX_DEG = 16,
  parameter int N_MU    = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_last_i,
  input logic            in_ready_o,
  input logic            out_valid_o,
  input logic [N_MU-1:0] out_msg_o,
  input logic            out_last_o
);
  localparam logic [N_MU-1:0] MOST_NEG = {1'b1, {(N_MU-1){1'b0}}};

  int in_cnt, out_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt  <= 0;
      out_cnt <= 0;
    end else if (out_valid_o && out_last_o) begin
      in_cnt  <= 0;
      out_cnt <= 0;
    end else begin
      if (in_valid_i && in_ready_o) in_cnt <= in_cnt + 1;
      if (out_valid_o)              out_cnt <= out_cnt + 1;
    end
  end

  a_r11_no_most_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_msg_o != MOST_NEG));

  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  a_r9_ready_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_last_i) |=> !in_ready_o);

  a_r7_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  a_r7_count_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o) |-> (out_cnt + 1 == in_cnt));

  a_r8_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> out_valid_o);

  a_r10_degree_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_cnt <= MAX_DEG);

endmodule

bind cnp_check_node cnp_check_node_chk #(.MAX_DEG(MAX_DEG), .N_MU(N_MU)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
  .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_msg_o(out_msg_o),
  .out_last_o(out_last_o)
);

// File: tb/cnp_check_node_test.sv
module cnp_check_node_test;
  localparam int MAXD = 16;
  localparam int NMU  = 6;
  localparam int SMU  = 1;
  localparam int NA   = 8;
  localparam int SA   = 0;
  localparam int TA   = 1;
  localparam int MA   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [NMU-1:0] in_msg = '0;
  logic in_ready, out_valid, out_last;
  logic [NMU-1:0] out_msg;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int mu [MAXD];
  int exp_out [MAXD];

  always #5 clk = ~clk;

  cnp_check_node #(.MAX_DEG(MAXD), .N_MU(NMU), .SH_MU(SMU), .N_A(NA), .SH_A(SA),
                   .T_A(TA), .M_A(MA)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_msg_i(in_msg),
    .in_last_i(in_last), .in_ready_o(in_ready), .out_valid_o(out_valid),
    .out_msg_o(out_msg), .out_last_o(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int corr(input int d);
    if (d == 0) return 3;
    else if (d <= 3) return 2;
    else if (d <= 8) return 1;
    return 0;
  endfunction

  function automatic int mstar(input int p, input int q, input int w);
    int mx, s, lim;
    mx  = (p > q) ? p : q;
    s   = mx + corr((p > q) ? p - q : q - p);
    lim = (1 << (w - 1)) - 1;
    return (s > lim) ? lim : s;
  endfunction

  function automatic int fstep(input int x, input int xw, input int xs,
                               input int y, input int yw, input int ys,
                               input int ow, input int os);
    int w, xf, yf, d, q, lim;
    w   = ((xw + xs) > (yw + ys) ? (xw + xs) : (yw + ys)) + 2;
    xf  = x * (1 << xs);
    yf  = y * (1 << ys);
    d   = mstar(xf, yf, w) - mstar(xf + yf, 0, w);
    q   = d >>> os;
    lim = (1 << (ow - 1)) - 1;
    if (q > lim) q = lim;
    if (q < -lim) q = -lim;
    return q;
  endfunction

  function automatic void ref_model(input int deg);
    int a, b, s, slim;
    int rd [MAXD];
    slim = (1 << (MA - 1)) - 1;
    a = (1 << (NA - 1)) - 1;
    for (int k = 0; k < deg; k++) begin
      s = a >>> TA;
      if (s > slim) s = slim;
      if (s < -slim) s = -slim;
      rd[k] = s * (1 << TA);
      a = fstep(a, NA, SA, mu[k], NMU, SMU, NA, SA);
    end
    b = (1 << (NA - 1)) - 1;
    for (int k = deg - 1; k >= 0; k--) begin
      exp_out[k] = fstep(rd[k], MA + TA, SA, b, NA, SA, NMU, SMU);
      b = fstep(b, NA, SA, mu[k], NMU, SMU, NA, SA);
    end
  endfunction

  // drive on falling edges; n counts falling edges after the accepting rising edge
  task automatic run_check(input int deg, input bit use_last, input bit gaps, input bit poke);
    ref_model(deg);
    for (int i = 0; i < deg; i++) begin
      if (gaps && (i % 2 == 1)) begin
        in_valid = 1'b0;
        in_msg   = NMU'($urandom_range(63));
        in_last  = 1'b1;          // R12: idle cycle, marker ignored
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_msg   = NMU'(mu[i]);
      in_last  = use_last && (i == deg - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(in_ready == 1'b0, "R9 ready low after last edge", int'(in_ready), 0);
    for (int t = 0; t < deg; t++) begin
      chk(out_valid == 1'b0, "R8 no output during backward pass", int'(out_valid), 0);
      if (poke) begin
        in_valid = 1'b1;
        in_msg   = NMU'($urandom_range(63));
        in_last  = 1'b1;
      end
      @(negedge clk);
    end
    for (int k = 0; k < deg; k++) begin
      chk(out_valid == 1'b1, "R8 output valid", int'(out_valid), 1);
      chk(int'($signed(out_msg)) == exp_out[k],
          "R3 extrinsic value (R2 R4 R5 R6)", int'($signed(out_msg)), exp_out[k]);
      chk(out_last == (k == deg - 1), "R7 last marker", int'(out_last), int'(k == deg - 1));
      if (poke && k < deg - 1) begin
        in_valid = 1'b1;
        in_last  = 1'b1;
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 ready after final output",
        int'({in_ready, out_valid}), 2);
  endtask

  task automatic rand_mu(input int deg);
    for (int i = 0; i < deg; i++) mu[i] = int'($urandom_range(62)) - 31;
  endtask

  initial begin
    void'($urandom(32'd2024));
    #2;
    chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 no output in reset", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 state after reset",
        int'({in_ready, out_valid}), 2);

    // degree 2
    mu[0] = 10; mu[1] = -7;
    run_check(2, 1'b1, 1'b0, 1'b0);
    // full degree, saturating magnitudes (R5 R6)
    for (int i = 0; i < MAXD; i++) mu[i] = (i % 2 == 0) ? 31 : -31;
    run_check(MAXD, 1'b1, 1'b0, 1'b0);
    // all zero
    for (int i = 0; i < 5; i++) mu[i] = 0;
    run_check(5, 1'b1, 1'b0, 1'b0);
    // R10: closes at MAX_DEG without a marker
    rand_mu(MAXD);
    run_check(MAXD, 1'b0, 1'b0, 1'b0);
    // R12: idle gaps
    rand_mu(7);
    run_check(7, 1'b1, 1'b1, 1'b0);
    // R9: input poked while busy, then a clean check
    rand_mu(4);
    run_check(4, 1'b1, 1'b0, 1'b1);
    rand_mu(3);
    run_check(3, 1'b1, 1'b0, 1'b0);
    // constrained random
    for (int r = 0; r < 30; r++) begin
      int deg;
      deg = int'($urandom_range(MAXD - 2)) + 2;
      rand_mu(deg);
      run_check(deg, 1'b1, 1'($urandom_range(1)), 1'b0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule